// File: doc/BRIEF.md
# Privileged Trap Entry Controller

This block performs trap entry for a core with three privilege levels: user, supervisor and machine. A one-cycle request carries a cause code, an interrupt flag, the address of the trapping instruction and a trap value. The controller decides which level handles the trap by walking a two-stage delegation chain. Interrupts and synchronous exceptions each have their own pair of masks. In the same clock edge it records the cause, the return address and the trap value in the handling level's registers, pushes that level's interrupt-enable stack, and switches the current privilege.

In the request cycle the redirect address is presented combinationally. It comes from the handling level's vector register. That register can select a vectored mode, which applies to interrupts only. After reset the block sits in machine mode with a cleared machine cause. In the first cycle after reset is released it presents a fixed boot address as a redirect. A simple configuration write port loads the delegation masks, the vector registers, the status word and the privilege, so that system code or a bench can set them up.

Top module: `trap_entry_ctrl`

## Requirements
- R1: While reset is held and afterwards: privilege reads 3 (machine), every status bit reads 0, machine cause reads 0. In the first cycle after reset is released, redirect_valid_o is 1 and redirect_pc_o equals the RESET_VEC parameter. In the next cycle without a trap, redirect_valid_o is 0.
- R2: For an interrupt, the handler is machine by default. It becomes supervisor (1) when the current privilege is not machine and bit `code` of the machine interrupt mask (select 0) is set. Independently of that, it becomes user (0) when the current privilege is user and bit `code` of the supervisor interrupt mask (select 1) is set.
- R3: For an exception the same rule applies, using the machine exception mask (select 2) and the supervisor exception mask (select 3).
- R4: A trap to machine sets mpp (status bits 8:7) to the old privilege and mpie (bit 6) to the old mie (bit 5), and clears mie. All other status bits are kept.
- R5: A trap to supervisor sets spp (bit 4) to bit 0 of the old privilege and spie (bit 3) to the old sie (bit 2), and clears sie. All other status bits are kept.
- R6: A trap to user sets upie (bit 1) to the old uie (bit 0) and clears uie. All other status bits are kept. Status bit 9 (mprv) is changed only by reset or a status write.
- R7: The handling level's cause register receives the zero-extended code, with bit XLEN-1 set for interrupts. The cause, return-address and trap-value registers of the other two levels are unchanged.
- R8: The handling level's return-address register receives trap_pc_i and its trap-value register receives trap_tval_i. The privilege becomes the handling level.
- R9: In a trap cycle redirect_valid_o is 1 and redirect_pc_o is the handling level's vector register (machine select 4, supervisor 5, user 6) with bits 1:0 cleared.
- R10: When the trap is an interrupt and the vector register's bits 1:0 equal 1, redirect_pc_o is the cleared base plus 4 times the code. Exceptions with mode 1, and any trap with mode 2 or 3, use the plain base.
- R11: When cfg_we_i is 1, select values 0 to 6 load the addressed mask or vector register from cfg_wdata_i. Select 7 loads status bits 9:0. Select 8 loads the privilege from bits 1:0, where value 2 is stored as 3. Other select values have no effect.
- R12: A cycle with neither trap_valid_i nor cfg_we_i changes no output register, and redirect_valid_o stays 0 outside the boot cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| trap_valid_i | input | 1 | One-cycle trap request strobe |
| trap_irq_i | input | 1 | Request is an interrupt |
| trap_code_i | input | CODE_W | Cause code |
| trap_pc_i | input | XLEN | Address of trapping instruction |
| trap_tval_i | input | XLEN | Trap value |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_sel_i | input | 4 | Configuration register select |
| cfg_wdata_i | input | XLEN | Configuration write data |
| priv_o | output | 2 | Current privilege (0 user, 1 supervisor, 3 machine) |
| stat_o | output | 10 | Status word |
| redirect_valid_o | output | 1 | Redirect strobe |
| redirect_pc_o | output | XLEN | Redirect address |
| m_cause_o | output | XLEN | Machine cause |
| m_epc_o | output | XLEN | Machine return address |
| m_tval_o | output | XLEN | Machine trap value |
| s_cause_o | output | XLEN | Supervisor cause |
| s_epc_o | output | XLEN | Supervisor return address |
| s_tval_o | output | XLEN | Supervisor trap value |
| u_cause_o | output | XLEN | User cause |
| u_epc_o | output | XLEN | User return address |
| u_tval_o | output | XLEN | User trap value |

## Verification
The bench aims at the delegation corners. One is user privilege with only the supervisor-stage bit set: a design that chains the stages would send that trap to machine instead of user. Another is interrupt and exception masks that disagree for the same code: swapping them misroutes the trap. Vector mode 1 on an exception, and modes 2 and 3 on an interrupt, are aimed at too: a design that mis-decodes the mode would add the code offset where none belongs. The bench also catches a status stack that pushes the wrong level's enable, a missing interrupt bit in the cause, and a boot redirect that lingers past its single cycle.

// File: rtl/trap_entry_pkg.sv
package trap_entry_pkg;
  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [3:0] SEL_M_IDLG = 4'd0;
  localparam logic [3:0] SEL_S_IDLG = 4'd1;
  localparam logic [3:0] SEL_M_EDLG = 4'd2;
  localparam logic [3:0] SEL_S_EDLG = 4'd3;
  localparam logic [3:0] SEL_M_VEC  = 4'd4;
  localparam logic [3:0] SEL_S_VEC  = 4'd5;
  localparam logic [3:0] SEL_U_VEC  = 4'd6;
  localparam logic [3:0] SEL_STAT   = 4'd7;
  localparam logic [3:0] SEL_PRIV   = 4'd8;

  typedef struct packed {
    logic       mprv;
    logic [1:0] mpp;
    logic       mpie;
    logic       mie;
    logic       spp;
    logic       spie;
    logic       sie;
    logic       upie;
    logic       uie;
  } stat_t;
endpackage

// File: rtl/trap_deleg_sel.sv
module trap_deleg_sel
  import trap_entry_pkg::*;
#(
  parameter int XLEN   = 64,
  parameter int CODE_W = $clog2(XLEN)
) (
  input  logic [1:0]        cur_priv_i,
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic [XLEN-1:0]   m_idlg_i,
  input  logic [XLEN-1:0]   m_edlg_i,
  input  logic [XLEN-1:0]   s_idlg_i,
  input  logic [XLEN-1:0]   s_edlg_i,
  output logic [1:0]        target_o
);
  logic m_bit, s_bit;

  always_comb begin
    m_bit    = irq_i ? m_idlg_i[code_i] : m_edlg_i[code_i];
    s_bit    = irq_i ? s_idlg_i[code_i] : s_edlg_i[code_i];
    target_o = PRIV_M;
    if (cur_priv_i != PRIV_M && m_bit) target_o = PRIV_S;
    // second stage is evaluated independently of the first
    if (cur_priv_i == PRIV_U && s_bit) target_o = PRIV_U;
  end
endmodule

// File: rtl/trap_vec_gen.sv
module trap_vec_gen #(
  parameter int XLEN   = 64,
  parameter int CODE_W = $clog2(XLEN)
) (
  input  logic [XLEN-1:0]   tvec_i,
  input  logic              irq_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [XLEN-1:0]   addr_o
);
  localparam int PAD_W = XLEN - CODE_W - 2;

  logic [XLEN-1:0] base, offs;

  always_comb begin
    base   = {tvec_i[XLEN-1:2], 2'b00};
    offs   = {{PAD_W{1'b0}}, code_i, 2'b00};
    // bit 1 reserved: only mode 1 vectors
    addr_o = (irq_i && tvec_i[1:0] == 2'b01) ? base + offs : base;
  end
endmodule

// File: rtl/trap_status_stack.sv
module trap_status_stack
  import trap_entry_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trap_i,
  input  logic [1:0] target_i,
  input  logic [1:0] cur_priv_i,
  input  logic       wr_en_i,
  input  stat_t      wr_data_i,
  output stat_t      stat_o
);
  stat_t st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= '0;
    end else if (trap_i) begin
      unique case (target_i)
        PRIV_M: begin
          st_q.mpp  <= cur_priv_i;
          st_q.mpie <= st_q.mie;
          st_q.mie  <= 1'b0;
        end
        PRIV_S: begin
          st_q.spp  <= cur_priv_i[0];
          st_q.spie <= st_q.sie;
          st_q.sie  <= 1'b0;
        end
        default: begin
          st_q.upie <= st_q.uie;
          st_q.uie  <= 1'b0;
        end
      endcase
    end else if (wr_en_i) begin
      st_q <= wr_data_i;
    end
  end

  assign stat_o = st_q;

  // R4
  m_stack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && target_i == PRIV_M) |=> (!st_q.mie && st_q.mpie == $past(st_q.mie)
      && st_q.mpp == $past(cur_priv_i) && $stable(st_q.sie) && $stable(st_q.uie)));
  // R5
  s_stack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && target_i == PRIV_S) |=> (!st_q.sie && st_q.spie == $past(st_q.sie)
      && $stable(st_q.mie) && $stable(st_q.mpp) && $stable(st_q.uie)));
  // R6
  u_stack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_i && target_i == PRIV_U) |=> (!st_q.uie && st_q.upie == $past(st_q.uie)
      && $stable(st_q.mprv) && $stable(st_q.mie) && $stable(st_q.sie) && $stable(st_q.spp)));
endmodule

// File: rtl/trap_level_csrs.sv
module trap_level_csrs #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] cause_i,
  input  logic [XLEN-1:0] epc_i,
  input  logic [XLEN-1:0] tval_i,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] epc_o,
  output logic [XLEN-1:0] tval_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cause_o <= '0;
      epc_o   <= '0;
      tval_o  <= '0;
    end else if (we_i) begin
      cause_o <= cause_i;
      epc_o   <= epc_i;
      tval_o  <= tval_i;
    end
  end
endmodule

// File: rtl/trap_entry_ctrl.sv
module trap_entry_ctrl
  import trap_entry_pkg::*;
#(
  parameter int              XLEN      = 64,
  parameter int              CODE_W    = $clog2(XLEN),
  parameter logic [XLEN-1:0] RESET_VEC = 64'h0000_0000_0000_1000
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trap_valid_i,
  input  logic              trap_irq_i,
  input  logic [CODE_W-1:0] trap_code_i,
  input  logic [XLEN-1:0]   trap_pc_i,
  input  logic [XLEN-1:0]   trap_tval_i,
  input  logic              cfg_we_i,
  input  logic [3:0]        cfg_sel_i,
  input  logic [XLEN-1:0]   cfg_wdata_i,
  output logic [1:0]        priv_o,
  output logic [9:0]        stat_o,
  output logic              redirect_valid_o,
  output logic [XLEN-1:0]   redirect_pc_o,
  output logic [XLEN-1:0]   m_cause_o,
  output logic [XLEN-1:0]   m_epc_o,
  output logic [XLEN-1:0]   m_tval_o,
  output logic [XLEN-1:0]   s_cause_o,
  output logic [XLEN-1:0]   s_epc_o,
  output logic [XLEN-1:0]   s_tval_o,
  output logic [XLEN-1:0]   u_cause_o,
  output logic [XLEN-1:0]   u_epc_o,
  output logic [XLEN-1:0]   u_tval_o
);
  localparam int NLVL  = 3;
  localparam int PAD_W = XLEN - 1 - CODE_W;
  localparam int ST_W  = $bits(stat_t);

  logic [XLEN-1:0] m_idlg_q, s_idlg_q, m_edlg_q, s_edlg_q;
  logic [XLEN-1:0] m_vec_q, s_vec_q, u_vec_q, sel_vec, vec_addr;
  logic [1:0]      priv_q, target;
  logic            boot_q;
  logic [XLEN-1:0] cause_val;
  logic [NLVL-1:0] lvl_we;
  logic [XLEN-1:0] cause_a [NLVL];
  logic [XLEN-1:0] epc_a   [NLVL];
  logic [XLEN-1:0] tval_a  [NLVL];
  stat_t           stat;

  trap_deleg_sel #(.XLEN(XLEN), .CODE_W(CODE_W)) u_deleg (
    .cur_priv_i(priv_q), .irq_i(trap_irq_i), .code_i(trap_code_i),
    .m_idlg_i(m_idlg_q), .m_edlg_i(m_edlg_q),
    .s_idlg_i(s_idlg_q), .s_edlg_i(s_edlg_q),
    .target_o(target)
  );

  always_comb begin
    unique case (target)
      PRIV_M:  sel_vec = m_vec_q;
      PRIV_S:  sel_vec = s_vec_q;
      default: sel_vec = u_vec_q;
    endcase
  end

  trap_vec_gen #(.XLEN(XLEN), .CODE_W(CODE_W)) u_vec (
    .tvec_i(sel_vec), .irq_i(trap_irq_i), .code_i(trap_code_i), .addr_o(vec_addr)
  );

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_idlg_q <= '0; s_idlg_q <= '0; m_edlg_q <= '0; s_edlg_q <= '0;
      m_vec_q  <= '0; s_vec_q  <= '0; u_vec_q  <= '0;
    end else if (cfg_we_i) begin
      unique case (cfg_sel_i)
        SEL_M_IDLG: m_idlg_q <= cfg_wdata_i;
        SEL_S_IDLG: s_idlg_q <= cfg_wdata_i;
        SEL_M_EDLG: m_edlg_q <= cfg_wdata_i;
        SEL_S_EDLG: s_edlg_q <= cfg_wdata_i;
        SEL_M_VEC:  m_vec_q  <= cfg_wdata_i;
        SEL_S_VEC:  s_vec_q  <= cfg_wdata_i;
        SEL_U_VEC:  u_vec_q  <= cfg_wdata_i;
        default: ;
      endcase
    end
  end

  // privilege and boot redirect
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      priv_q <= PRIV_M;
      boot_q <= 1'b1;
    end else begin
      boot_q <= 1'b0;
      if (trap_valid_i) priv_q <= target;
      else if (cfg_we_i && cfg_sel_i == SEL_PRIV)
        priv_q <= (cfg_wdata_i[1:0] == 2'd2) ? PRIV_M : cfg_wdata_i[1:0];
    end
  end

  trap_status_stack u_stat (
    .clk_i(clk_i), .rst_ni(rst_ni), .trap_i(trap_valid_i),
    .target_i(target), .cur_priv_i(priv_q),
    .wr_en_i(cfg_we_i && cfg_sel_i == SEL_STAT),
    .wr_data_i(stat_t'(cfg_wdata_i[ST_W-1:0])),
    .stat_o(stat)
  );

  assign cause_val = {trap_irq_i, {PAD_W{1'b0}}, trap_code_i};

  // level index: 0 user, 1 supervisor, 2 machine
  for (genvar i = 0; i < NLVL; i++) begin : g_lvl
    localparam logic [1:0] LVL_PRIV = (i == 0) ? PRIV_U : (i == 1) ? PRIV_S : PRIV_M;
    assign lvl_we[i] = trap_valid_i && target == LVL_PRIV;
    trap_level_csrs #(.XLEN(XLEN)) u_csrs (
      .clk_i(clk_i), .rst_ni(rst_ni), .we_i(lvl_we[i]),
      .cause_i(cause_val), .epc_i(trap_pc_i), .tval_i(trap_tval_i),
      .cause_o(cause_a[i]), .epc_o(epc_a[i]), .tval_o(tval_a[i])
    );
  end

  assign priv_o           = priv_q;
  assign stat_o           = stat;
  assign redirect_valid_o = trap_valid_i || boot_q;
  assign redirect_pc_o    = trap_valid_i ? vec_addr : RESET_VEC;
  assign u_cause_o = cause_a[0]; assign u_epc_o = epc_a[0]; assign u_tval_o = tval_a[0];
  assign s_cause_o = cause_a[1]; assign s_epc_o = epc_a[1]; assign s_tval_o = tval_a[1];
  assign m_cause_o = cause_a[2]; assign m_epc_o = epc_a[2]; assign m_tval_o = tval_a[2];

  // R2 R3
  m_no_deleg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && priv_q == PRIV_M) |=> priv_q == PRIV_M);
  // R2 R3
  u_only_from_u_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && priv_q == PRIV_S) |=> priv_q != PRIV_U);
  // R7
  one_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) $onehot0(lvl_we));
  // R7
  m_cause_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && target != PRIV_M) |=> $stable(m_cause_o));
  // R9
  redirect_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_valid_i && !trap_irq_i) |-> redirect_pc_o[1:0] == 2'b00);
  // R12
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trap_valid_i && !cfg_we_i) |=> ($stable(priv_q) && $stable(stat_o) && $stable(m_epc_o)));
endmodule

// File: tb/trap_entry_ctrl_bench.sv
`timescale 1ns/1ps
module trap_entry_ctrl_bench;
  localparam int XLEN = 64;
  localparam int CW   = 6;
  localparam logic [63:0] RV = 64'h0000_0000_0000_1000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_valid = 0, trap_irq = 0, cfg_we = 0;
  logic [CW-1:0] trap_code = '0;
  logic [63:0] trap_pc = '0, trap_tval = '0, cfg_wdata = '0;
  logic [3:0] cfg_sel = '0;
  logic [1:0] priv;
  logic [9:0] stat;
  logic rv_o;
  logic [63:0] rpc, mc, me, mt, sc, se, st, uc, ue, ut;

  int checks = 0, errors = 0;

  // model state
  logic [63:0] m_idlg, s_idlg, m_edlg, s_edlg, m_vec, s_vec, u_vec;
  logic [1:0]  e_priv;
  logic [9:0]  e_st;
  logic [63:0] e_cause [3], e_epc [3], e_tval [3];

  always #2.5 clk = ~clk;

  trap_entry_ctrl #(.XLEN(XLEN), .RESET_VEC(RV)) u_trap_entry_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .trap_valid_i(trap_valid), .trap_irq_i(trap_irq),
    .trap_code_i(trap_code), .trap_pc_i(trap_pc), .trap_tval_i(trap_tval),
    .cfg_we_i(cfg_we), .cfg_sel_i(cfg_sel), .cfg_wdata_i(cfg_wdata),
    .priv_o(priv), .stat_o(stat), .redirect_valid_o(rv_o), .redirect_pc_o(rpc),
    .m_cause_o(mc), .m_epc_o(me), .m_tval_o(mt), .s_cause_o(sc), .s_epc_o(se),
    .s_tval_o(st), .u_cause_o(uc), .u_epc_o(ue), .u_tval_o(ut)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [1:0] f_target(input logic [1:0] p, input logic irq, input logic [CW-1:0] c);
    logic mb, sb;
    logic [1:0] t;
    mb = irq ? m_idlg[c] : m_edlg[c];
    sb = irq ? s_idlg[c] : s_edlg[c];
    t = 2'd3;
    if (p != 2'd3 && mb) t = 2'd1;
    if (p == 2'd0 && sb) t = 2'd0;
    return t;
  endfunction

  function automatic logic [63:0] f_vec(input logic [1:0] t, input logic irq, input logic [CW-1:0] c);
    logic [63:0] v;
    v = (t == 2'd3) ? m_vec : (t == 2'd1) ? s_vec : u_vec;
    if (irq && v[1:0] == 2'b01) return {v[63:2], 2'b00} + 64'(c) * 4;
    return {v[63:2], 2'b00};
  endfunction

  task automatic check_regs(input string req);
    chk({req, " priv"}, 64'(priv), 64'(e_priv));
    chk({req, " stat"}, 64'(stat), 64'(e_st));
    chk({req, " mcause"}, mc, e_cause[2]); chk({req, " mepc"}, me, e_epc[2]); chk({req, " mtval"}, mt, e_tval[2]);
    chk({req, " scause"}, sc, e_cause[1]); chk({req, " sepc"}, se, e_epc[1]); chk({req, " stval"}, st, e_tval[1]);
    chk({req, " ucause"}, uc, e_cause[0]); chk({req, " uepc"}, ue, e_epc[0]); chk({req, " utval"}, ut, e_tval[0]);
  endtask

  task automatic cfg(input logic [3:0] sel, input logic [63:0] d);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_we = 0;
    case (sel)
      4'd0: m_idlg = d; 4'd1: s_idlg = d; 4'd2: m_edlg = d; 4'd3: s_edlg = d;
      4'd4: m_vec = d;  4'd5: s_vec = d;  4'd6: u_vec = d;  4'd7: e_st = d[9:0];
      4'd8: e_priv = (d[1:0] == 2'd2) ? 2'd3 : d[1:0];
      default: ;
    endcase
    @(negedge clk);
    check_regs("R11 cfg");
  endtask

  task automatic trap(input logic irq, input logic [CW-1:0] c, input logic [63:0] pc, input logic [63:0] tv, input string req);
    logic [1:0] t;
    int idx;
    trap_valid = 1; trap_irq = irq; trap_code = c; trap_pc = pc; trap_tval = tv;
    t = f_target(e_priv, irq, c);
    #1;
    chk({req, " R9 redirect_valid"}, 64'(rv_o), 64'd1);
    chk({req, " R9 R10 redirect_pc"}, rpc, f_vec(t, irq, c));
    @(posedge clk); #1;
    trap_valid = 0;
    idx = (t == 2'd3) ? 2 : (t == 2'd1) ? 1 : 0;
    e_cause[idx] = 64'(c) | (irq ? 64'h8000_0000_0000_0000 : 64'd0);
    e_epc[idx] = pc; e_tval[idx] = tv;
    case (t)
      2'd3: begin e_st[8:7] = e_priv; e_st[6] = e_st[5]; e_st[5] = 1'b0; end
      2'd1: begin e_st[4] = e_priv[0]; e_st[3] = e_st[2]; e_st[2] = 1'b0; end
      default: begin e_st[1] = e_st[0]; e_st[0] = 1'b0; end
    endcase
    e_priv = t;
    @(negedge clk);
    check_regs({req, " R4 R5 R6 R7 R8"});
  endtask

  initial begin
    #(5.0 * 200000);
    errors++;
    $display("FAIL watchdog act=%h exp=%h", 64'd0, 64'd1);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [3:0] s;
    logic [63:0] d;
    void'($urandom(32'd4242));
    m_idlg = 0; s_idlg = 0; m_edlg = 0; s_edlg = 0; m_vec = 0; s_vec = 0; u_vec = 0;
    e_priv = 2'd3; e_st = 0;
    for (int i = 0; i < 3; i++) begin e_cause[i] = 0; e_epc[i] = 0; e_tval[i] = 0; end
    repeat (3) @(negedge clk);
    check_regs("R1 in reset");
    rst_n = 1;
    #1;
    chk("R1 boot redirect_valid", 64'(rv_o), 64'd1);
    chk("R1 boot pc", rpc, RV);
    @(negedge clk);
    chk("R1 boot over", 64'(rv_o), 64'd0);
    check_regs("R1 after reset");

    // R12 idle cycles
    repeat (3) @(negedge clk);
    chk("R12 idle redirect", 64'(rv_o), 64'd0);
    check_regs("R12 idle");

    // R11 unused select ignored
    cfg(4'd9, 64'hFFFF_FFFF_FFFF_FFFF);
    cfg(4'd8, 64'd2);            // stored as machine
    // directed vector modes (machine handler)
    cfg(4'd4, 64'h0000_8000_0000_0101);
    trap(1'b1, 6'd5, 64'h100, 64'h11, "R10 vectored irq");
    trap(1'b0, 6'd5, 64'h104, 64'h12, "R10 exc ignores mode");
    cfg(4'd4, 64'h0000_8000_0000_0203);
    trap(1'b1, 6'd7, 64'h108, 64'h13, "R10 mode3 direct");
    cfg(4'd4, 64'h0000_8000_0000_0302);
    trap(1'b1, 6'd9, 64'h10C, 64'h14, "R10 mode2 direct");

    // R2 R3 disagreeing masks and second-stage only
    cfg(4'd0, 64'h0000_0000_0000_0010);   // irq code 4 -> S
    cfg(4'd2, 64'h0000_0000_0000_0020);   // exc code 5 -> S
    cfg(4'd1, 64'h0000_0000_0000_0008);   // irq code 3 -> U
    cfg(4'd3, 64'h0000_0000_0000_0040);   // exc code 6 -> U
    cfg(4'd5, 64'h0000_4000_0000_0001);
    cfg(4'd6, 64'h0000_2000_0000_0001);
    cfg(4'd7, 64'h3FF);
    cfg(4'd8, 64'd1);
    trap(1'b1, 6'd4, 64'h200, 64'h21, "R2 irq S->S");
    cfg(4'd8, 64'd1);
    trap(1'b0, 6'd4, 64'h204, 64'h22, "R3 exc code4 stays M");
    cfg(4'd8, 64'd0);
    cfg(4'd7, 64'h3FF);
    trap(1'b1, 6'd3, 64'h208, 64'h23, "R2 U via second stage only");
    cfg(4'd7, 64'h3FF);
    trap(1'b0, 6'd6, 64'h20C, 64'h24, "R3 exc U");
    cfg(4'd8, 64'd0);
    trap(1'b0, 6'd5, 64'h210, 64'h25, "R3 exc U->S");

    // random mix
    for (int n = 0; n < 600; n++) begin
      s = 4'($urandom_range(0, 9));
      d = {$urandom, $urandom};
      if ($urandom_range(0, 2) == 0) begin
        if (s == 4'd8) d[1:0] = (d[1:0] == 2'd2) ? 2'd0 : d[1:0];
        cfg(s, d);
      end else begin
        trap(1'($urandom), CW'($urandom), {$urandom, $urandom}, {$urandom, $urandom}, "rand");
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule